// File: doc/BRIEF.md
# Interleaved Video Fetch Load Scheduler

This block sits on the memory-controller side of a shared RAM bus. It splits bus time into four-clock access slots and alternates them: one slot for the CPU, then one slot for video fetch. It repeats this eight-clock period for as long as it runs. In each video slot it does one of two things. If the display is active, it sends a one-clock load strobe to a downstream pixel shifter. If not, it spends the slot on a DRAM refresh strobe.

Display enable comes from a separate timing generator. That generator runs on the same clock as the slot counter, but its cycle position is shifted by a 2-bit offset of 0 to 3 clocks. The scheduler takes in the enable only at the generator's own cycle boundary inside the CPU slot. Because of this, the delay from a rising enable to the first load strobe depends on the offset: 6 minus the offset, so 3 to 6 clocks. The offset is a static setting, captured while reset is held.

CPU requests are sampled once per period. A sampled request is granted for the whole of the next CPU slot. With no request, that CPU slot idles.

Top module: `vfetch_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, the slot counter is at cycle 0 of a CPU slot: `slot_video` is 0 and `load_pulse`, `refresh_pulse` and `cpu_grant` are 0.
- R2: Slots are four clocks long and alternate CPU (`slot_video`=0) and video (`slot_video`=1). The first slot after reset is a CPU slot.
- R3: `load_pulse` is exactly one clock wide. It is high only in cycle 2 (counting from 0) of a video slot.
- R4: `de_in` is sampled at exactly one edge per eight-clock period: the edge that ends CPU-slot cycle k, where k is the captured offset. A video slot carries a load strobe exactly when the latest such sample was 1. `de_in` values at all other edges are ignored.
- R5: Suppose `de_in` is first presented high at the sampling edge of R4. Then `load_pulse` is high after 6−k clock edges, counting that sampling edge as the first. With k = 0..3 this gives 6, 5, 4 or 3.
- R6: `refresh_pulse` is a one-clock pulse in cycle 2 of every video slot that has no load strobe. Every video slot carries exactly one of load or refresh, and never both.
- R7: `cpu_req` is sampled at the edge that ends the last cycle of a video slot. `cpu_grant` is high for all four cycles of the next CPU slot exactly when that sample was 1, and is never high in a video slot.
- R8: `phase_off` is captured only while reset is held. Changing it after reset does not change the sampling point of R4.
- R9: When `de_in` is sampled low, no load strobe follows until a later sample is high. The slot in progress keeps its normal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the scheduler and the timing generator |
| rst | input | 1 | Synchronous reset, active high |
| de_in | input | 1 | Display enable level from the timing generator |
| phase_off | input | 2 | Static offset of the generator cycle relative to the slot counter |
| cpu_req | input | 1 | CPU bus request |
| load_pulse | output | 1 | One-clock load strobe to the pixel shifter |
| cpu_grant | output | 1 | High for a whole CPU slot when a request was sampled |
| refresh_pulse | output | 1 | One-clock refresh strobe in an unused video slot |
| slot_video | output | 1 | Slot owner: 1 for video, 0 for CPU |

## Verification
The assertions look only at the outputs and a four-cycle count kept inside the checker. Because of that, they assume nothing about how `de_in` or `cpu_req` behave; they need only that reset is applied synchronously. The latency figures of R5 hold only when the enable changes at the generator's boundary, so the directed latency cases raise `de_in` just before the sampling edge. The random phases toggle `de_in` and `cpu_req` at arbitrary clocks. A bench model that knows only the sampling rules predicts every output, and this is how the rule that other edges are ignored gets checked.

// File: rtl/vfetch_sched.sv
module vfetch_sched #(
  parameter int SLOT_CYC = 4,
  parameter int LOAD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       de_in,
  input  logic [1:0] phase_off,
  input  logic       cpu_req,
  output logic       load_pulse,
  output logic       cpu_grant,
  output logic       refresh_pulse,
  output logic       slot_video
);
  localparam int CW = $clog2(SLOT_CYC);
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0] PRE_LOAD = CW'(LOAD_CYC - 1);

  logic [CW-1:0] cyc;
  logic          vid;
  logic [1:0]    ph_q;
  logic          de_q;
  logic          ld_q, rf_q, gnt_q;

  wire at_sample = !vid && (cyc == CW'(ph_q));
  wire at_fetch  = vid && (cyc == PRE_LOAD);
  wire end_vid   = vid && (cyc == LAST);
  wire end_cpu   = !vid && (cyc == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc   <= '0;
      vid   <= 1'b0;
      ph_q  <= phase_off;
      de_q  <= 1'b0;
      ld_q  <= 1'b0;
      rf_q  <= 1'b0;
      gnt_q <= 1'b0;
    end else begin
      cyc <= (cyc == LAST) ? '0 : cyc + 1'b1;
      if (cyc == LAST) vid <= ~vid;
      if (at_sample) de_q <= de_in;
      ld_q <= at_fetch && de_q;
      rf_q <= at_fetch && !de_q;
      if (end_vid) gnt_q <= cpu_req;
      else if (end_cpu) gnt_q <= 1'b0;
    end
  end

  assign load_pulse    = ld_q;
  assign refresh_pulse = rf_q;
  assign cpu_grant     = gnt_q;
  assign slot_video    = vid;
endmodule

module vfetch_sched_chk (
  input logic clk,
  input logic rst,
  input logic load_pulse,
  input logic cpu_grant,
  input logic refresh_pulse,
  input logic slot_video
);
  logic [1:0] cnt;
  logic       sv_q;
  always_ff @(posedge clk) begin
    cnt  <= rst ? 2'd0 : cnt + 2'd1;
    sv_q <= rst ? 1'b0 : slot_video;
  end

  // R2
  owner_switch_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_video != sv_q) |-> (cnt == 2'd0));
  // R3
  load_width_chk: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> !load_pulse);
  // R3
  load_in_video_chk: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> (slot_video && cnt == 2'd2));
  // R6
  refresh_excl_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_pulse |-> (!load_pulse && slot_video && cnt == 2'd2));
  // R6
  one_per_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_video && cnt == 2'd3) |-> ($past(load_pulse) != $past(refresh_pulse)));
  // R7
  grant_cpu_only_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_grant |-> !slot_video);
  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!slot_video && cnt != 2'd0) |-> $stable(cpu_grant));
endmodule

bind vfetch_sched vfetch_sched_chk u_chk (
  .clk(clk), .rst(rst), .load_pulse(load_pulse), .cpu_grant(cpu_grant),
  .refresh_pulse(refresh_pulse), .slot_video(slot_video)
);

// File: tb/vfetch_sched_test.sv
module vfetch_sched_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic de_in = 1'b0;
  logic [1:0] phase_off = 2'd0;
  logic cpu_req = 1'b0;
  logic load_pulse, cpu_grant, refresh_pulse, slot_video;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_pos = 0;
  int m_ph = 0;
  bit m_de = 0, m_ld = 0, m_rf = 0, m_gn = 0;

  always #4 clk = ~clk;

  vfetch_sched uut (
    .clk(clk), .rst(rst), .de_in(de_in), .phase_off(phase_off), .cpu_req(cpu_req),
    .load_pulse(load_pulse), .cpu_grant(cpu_grant), .refresh_pulse(refresh_pulse),
    .slot_video(slot_video)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_video(input int pos);
    return pos >= 4;
  endfunction

  task automatic tick();
    bit a_rst = rst, a_de = de_in, a_req = cpu_req;
    int a_ph = phase_off;
    @(posedge clk);
    @(negedge clk);
    if (a_rst) begin
      m_pos = 0; m_de = 0; m_ld = 0; m_rf = 0; m_gn = 0; m_ph = a_ph;
    end else begin
      m_ld = (m_pos == 5) && m_de;
      m_rf = (m_pos == 5) && !m_de;
      if (m_pos == 7) m_gn = a_req;
      else if (m_pos == 3) m_gn = 0;
      if (m_pos == m_ph) m_de = a_de;
      m_pos = (m_pos + 1) % 8;
    end
    chk(slot_video == exp_video(m_pos), "R2 slot_video", slot_video, exp_video(m_pos));
    chk(load_pulse == m_ld, "R3/R4 load_pulse", load_pulse, m_ld);
    chk(refresh_pulse == m_rf, "R6 refresh_pulse", refresh_pulse, m_rf);
    chk(cpu_grant == m_gn, "R7 cpu_grant", cpu_grant, m_gn);
  endtask

  task automatic do_reset(input logic [1:0] ph);
    rst = 1'b1; phase_off = ph; de_in = 1'b0; cpu_req = 1'b0;
    repeat (3) tick();
    chk(slot_video == 1'b0 && load_pulse == 1'b0 && refresh_pulse == 1'b0 && cpu_grant == 1'b0,
        "R1 reset state", {slot_video, load_pulse, refresh_pulse, cpu_grant}, 0);
    rst = 1'b0;
    tick();
    chk(slot_video == 1'b0 && cpu_grant == 1'b0, "R1 first cycle",
        {slot_video, cpu_grant}, 0);
  endtask

  task automatic latency(input int ph);
    int n;
    while (m_pos != ph) tick();
    de_in = 1'b1;
    n = 0;
    do begin
      tick();
      n++;
    end while (!load_pulse && n < 12);
    chk(n == 6 - ph, "R5 enable-to-load latency", n, 6 - ph);
    de_in = 1'b0;
    while (m_pos != ph) tick();
    tick();
    n = 0;
    for (int i = 0; i < 16; i++) begin
      tick();
      if (load_pulse) n++;
    end
    chk(n == 0, "R9 no load after enable low", n, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    for (int ph = 0; ph < 4; ph++) begin
      do_reset(2'(ph));
      latency(ph);
    end
    do_reset(2'd3);
    phase_off = 2'd0;
    latency(3);
    chk(m_ph == 3, "R8 offset held after reset", m_ph, 3);
    do_reset(2'd1);
    while (m_pos != 7) tick();
    cpu_req = 1'b1;
    tick();
    cpu_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(cpu_grant == 1'b1, "R7 grant whole slot", cpu_grant, 1);
      tick();
    end
    chk(cpu_grant == 1'b0, "R7 grant ends with slot", cpu_grant, 0);
    for (int ep = 0; ep < 6; ep++) begin
      do_reset(2'($urandom % 4));
      for (int i = 0; i < 600; i++) begin
        if ($urandom % 5 == 0) de_in = ~de_in;
        cpu_req = ($urandom % 2) == 1;
        if (ep % 2 == 1) phase_off = 2'($urandom % 4);
        tick();
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule